// File: doc/BRIEF.md
# Streaming Frame-Difference Hit Detector

This block sits behind the analogue-to-digital converters of a pixel-sensor readout and turns a raw stream of 12-bit pixel codes into hit candidates. It takes one sample per clock, qualified by a valid strobe, with a marker on the sample that opens a frame. For every pixel it first applies a linear gain and offset correction chosen by the converter channel that digitised it. It then subtracts the corrected value that the same pixel position held one frame earlier, which removes fixed pattern and reset level (correlated double sampling).

The difference is scaled down by a programmable right shift and clamped to a narrow signed word. That word is compared against a programmable threshold to mark hits. The previous-frame values live in an internal memory sized by the row and column parameters. Every accepted sample produces exactly one output, in input order, carrying the reduced difference, the hit flag and the pixel's row and column. The frame size defaults to a small array; the nominal 360 by 640 sensor is reached by overriding `ROWS` and `COLS`.

Top module: `fdh_hit_detector`

## Requirements
- R1: While reset is held and after its release with no input, `out_valid` and `out_hit` are 0.
- R2: Each sample accepted with `in_valid` high gives exactly one output with `out_valid` high 4 clock edges later. Outputs come out in input order, and `out_valid` is never high for a cycle that had no input.
- R3: Positions advance only on accepted samples. The column counts up from 0 to `COLS-1` and then wraps to 0 while the row moves up by one. The row wraps from `ROWS-1` to 0. `in_sof` is ignored while `in_valid` is low.
- R4: The calibration channel of a sample is its column modulo `NUM_CH` (the low bits of the column). Channel k takes its signed slope from `cal_slope[k*SLOPE_W +: SLOPE_W]` and its signed offset from `cal_offset[k*OFS_W +: OFS_W]`. The corrected value is code + floor(slope*code / 2^FRAC_W) + offset, with FRAC_W = 8.
- R5: The corrected value is clamped to the range 0 to 4095.
- R6: The difference is the corrected value of the sample minus the corrected value stored for the same row and column by the most recent earlier sample at that position.
- R7: The difference is arithmetically right-shifted by `shift_amt`, which rounds toward minus infinity. It is then clamped to -128..127 and presented as two's complement on `out_diff`.
- R8: `out_hit` is 1 exactly when a previous frame exists and the signed `out_diff` is strictly greater than the signed `hit_thresh`.
- R9: Throughout the first frame after reset, `out_diff` is 0 and `out_hit` is 0. That frame's corrected values are still stored and serve as the reference for the second frame.
- R10: An accepted sample with `in_sof` high is placed at row 0, column 0, and it begins the next frame even when the previous frame was cut short.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A sample is present this cycle |
| in_sof | input | 1 | The sample is the first of a frame |
| in_data | input | DATA_W | Unsigned converter code |
| cal_slope | input | NUM_CH*SLOPE_W | Per-channel signed slope, 8 fractional bits |
| cal_offset | input | NUM_CH*OFS_W | Per-channel signed offset in code units |
| shift_amt | input | $clog2(DATA_W+1) | Right-shift applied to the difference |
| hit_thresh | input | RED_W | Signed hit threshold |
| out_valid | output | 1 | Output word present |
| out_diff | output | RED_W | Reduced signed difference |
| out_hit | output | 1 | Difference above threshold |
| out_row | output | $clog2(ROWS) | Row of the output pixel |
| out_col | output | $clog2(COLS) | Column of the output pixel |

## Verification
The hardest situation to reach from the ports is the interplay between stored history and a change of context. This covers a frame cut short by an early start marker, a calibration change between frames, and corrections that clamp at either end of the code range, whose effect only shows up one frame later as a difference. The bench keeps its own model of the stored corrected value at every position. It sends whole frames back to back and changes slopes and offsets between them so that clamping makes a visible difference. It restarts a frame after a few samples, and it spreads samples over gap cycles during which the start marker is held high without a valid strobe.

// File: rtl/fdh_pkg.sv
package fdh_pkg;
   // Clamp a signed integer into [lo, hi]
   function automatic int clamp_int(input int v, input int lo, input int hi);
      if (v < lo) return lo;
      if (v > hi) return hi;
      return v;
   endfunction
endpackage

// File: rtl/fdh_position.sv
module fdh_position #(
   parameter int ROWS = 16,
   parameter int COLS = 32,
   localparam int ROW_W  = $clog2(ROWS),
   localparam int COL_W  = $clog2(COLS),
   localparam int ADDR_W = $clog2(ROWS * COLS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic              in_sof,
   output logic [ROW_W-1:0]  row_now,
   output logic [COL_W-1:0]  col_now,
   output logic [ADDR_W-1:0] addr_now,
   output logic              prev_ok_now
);
   logic [ROW_W-1:0]  row_q;
   logic [COL_W-1:0]  col_q;
   logic [ADDR_W-1:0] addr_q;
   logic              started_q, have_prev_q;
   logic              origin, last_col, last_row;

   always_comb begin
      origin      = in_sof || (row_q == '0 && col_q == '0);
      row_now     = in_sof ? '0 : row_q;
      col_now     = in_sof ? '0 : col_q;
      addr_now    = in_sof ? '0 : addr_q;
      prev_ok_now = have_prev_q || (started_q && origin);
      last_col    = (col_now == COL_W'(COLS - 1));
      last_row    = (row_now == ROW_W'(ROWS - 1));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         row_q       <= '0;
         col_q       <= '0;
         addr_q      <= '0;
         started_q   <= 1'b0;
         have_prev_q <= 1'b0;
      end else if (in_valid) begin
         started_q   <= 1'b1;
         have_prev_q <= prev_ok_now;
         if (last_col) begin
            col_q <= '0;
            row_q <= last_row ? '0 : row_now + 1'b1;
         end else begin
            col_q <= col_now + 1'b1;
            row_q <= row_now;
         end
         addr_q <= (last_col && last_row) ? '0 : addr_now + 1'b1;
      end
   end
endmodule

// File: rtl/fdh_calib.sv
module fdh_calib import fdh_pkg::*; #(
   parameter int DATA_W  = 12,
   parameter int NUM_CH  = 4,
   parameter int SLOPE_W = 12,
   parameter int FRAC_W  = 8,
   parameter int OFS_W   = 13,
   localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
   localparam int PROD_W = DATA_W + SLOPE_W + 1
) (
   input  logic [DATA_W-1:0]         code,
   input  logic [CH_W-1:0]           ch,
   input  logic [NUM_CH*SLOPE_W-1:0] slope_bus,
   input  logic [NUM_CH*OFS_W-1:0]   offset_bus,
   output logic [DATA_W-1:0]         corrected
);
   logic signed [SLOPE_W-1:0] slope_sel;
   logic signed [OFS_W-1:0]   ofs_sel;
   logic signed [PROD_W-1:0]  prod, term;
   logic signed [PROD_W+1:0]  sum;

   generate
      if (NUM_CH == 1) begin : g_single
         assign slope_sel = slope_bus;
         assign ofs_sel   = offset_bus;
      end else begin : g_multi
         logic signed [SLOPE_W-1:0] slope_arr [NUM_CH];
         logic signed [OFS_W-1:0]   ofs_arr   [NUM_CH];
         for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
            assign slope_arr[c] = slope_bus[c*SLOPE_W +: SLOPE_W];
            assign ofs_arr[c]   = offset_bus[c*OFS_W +: OFS_W];
         end
         assign slope_sel = slope_arr[ch];
         assign ofs_sel   = ofs_arr[ch];
      end
   endgenerate

   always_comb begin
      prod      = $signed({1'b0, code}) * slope_sel;
      term      = prod >>> FRAC_W;
      sum       = $signed({1'b0, code}) + term + ofs_sel;
      corrected = DATA_W'(clamp_int(int'(sum), 0, (1 << DATA_W) - 1));
   end
endmodule

// File: rtl/fdh_reduce.sv
module fdh_reduce import fdh_pkg::*; #(
   parameter int DATA_W = 12,
   parameter int RED_W  = 8,
   localparam int SHIFT_W = $clog2(DATA_W + 1)
) (
   input  logic [DATA_W-1:0]  cur,
   input  logic [DATA_W-1:0]  prev,
   input  logic [SHIFT_W-1:0] shift,
   output logic [RED_W-1:0]   reduced
);
   logic signed [DATA_W:0] diff, scaled;

   always_comb begin
      diff    = $signed({1'b0, cur}) - $signed({1'b0, prev});
      scaled  = diff >>> shift;
      reduced = RED_W'(clamp_int(int'(scaled), -(1 << (RED_W - 1)), (1 << (RED_W - 1)) - 1));
   end
endmodule

// File: rtl/fdh_frame_store.sv
module fdh_frame_store #(
   parameter int DATA_W = 12,
   parameter int DEPTH  = 512,
   localparam int ADDR_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [ADDR_W-1:0] raddr,
   output logic [DATA_W-1:0] rdata
);
   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
      rdata <= mem[raddr];
   end
endmodule

// File: rtl/fdh_hit_detector.sv
module fdh_hit_detector #(
   parameter int DATA_W  = 12,
   parameter int ROWS    = 16,
   parameter int COLS    = 32,
   parameter int NUM_CH  = 4,
   parameter int SLOPE_W = 12,
   parameter int FRAC_W  = 8,
   parameter int OFS_W   = 13,
   parameter int RED_W   = 8,
   localparam int ROW_W   = $clog2(ROWS),
   localparam int COL_W   = $clog2(COLS),
   localparam int DEPTH   = ROWS * COLS,
   localparam int ADDR_W  = $clog2(DEPTH),
   localparam int SHIFT_W = $clog2(DATA_W + 1),
   localparam int CH_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      in_valid,
   input  logic                      in_sof,
   input  logic [DATA_W-1:0]         in_data,
   input  logic [NUM_CH*SLOPE_W-1:0] cal_slope,
   input  logic [NUM_CH*OFS_W-1:0]   cal_offset,
   input  logic [SHIFT_W-1:0]        shift_amt,
   input  logic [RED_W-1:0]          hit_thresh,
   output logic                      out_valid,
   output logic [RED_W-1:0]          out_diff,
   output logic                      out_hit,
   output logic [ROW_W-1:0]          out_row,
   output logic [COL_W-1:0]          out_col
);
   // Elaboration-time parameter checks
   generate
      if (ROWS < 2 || COLS < 2 || DEPTH < 4) begin : g_bad_frame
         $error("frame must be at least 2x2");
      end
      if (NUM_CH < 1 || (NUM_CH & (NUM_CH - 1)) != 0 || COLS < NUM_CH) begin : g_bad_ch
         $error("NUM_CH must be a power of two not above COLS");
      end
      if (DATA_W + SLOPE_W > 28 || OFS_W > 28 || FRAC_W >= DATA_W + SLOPE_W) begin : g_bad_cal
         $error("calibration widths out of range");
      end
      if (RED_W < 2 || RED_W > DATA_W + 1) begin : g_bad_red
         $error("RED_W must lie in 2..DATA_W+1");
      end
   endgenerate

   logic [ROW_W-1:0]  p_row;
   logic [COL_W-1:0]  p_col;
   logic [ADDR_W-1:0] p_addr;
   logic              p_prev_ok;

   fdh_position #(.ROWS(ROWS), .COLS(COLS)) i_pos (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
      .row_now(p_row), .col_now(p_col), .addr_now(p_addr), .prev_ok_now(p_prev_ok)
   );

   // Stage A: captured sample plus previous-frame read
   logic              a_valid, a_prev_ok;
   logic [ROW_W-1:0]  a_row;
   logic [COL_W-1:0]  a_col;
   logic [ADDR_W-1:0] a_addr;
   logic [DATA_W-1:0] a_code, a_prev;
   // Stage B: corrected value
   logic              b_valid, b_prev_ok;
   logic [ROW_W-1:0]  b_row;
   logic [COL_W-1:0]  b_col;
   logic [ADDR_W-1:0] b_addr;
   logic [DATA_W-1:0] b_corr, b_prev;
   // Stage C: reduced difference
   logic              c_valid, c_prev_ok;
   logic [ROW_W-1:0]  c_row;
   logic [COL_W-1:0]  c_col;
   logic [RED_W-1:0]  c_red;

   logic [DATA_W-1:0] corr_w;
   logic [RED_W-1:0]  red_w;

   fdh_frame_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) i_store (
      .clk(clk), .we(b_valid), .waddr(b_addr), .wdata(b_corr),
      .raddr(p_addr), .rdata(a_prev)
   );

   fdh_calib #(
      .DATA_W(DATA_W), .NUM_CH(NUM_CH), .SLOPE_W(SLOPE_W),
      .FRAC_W(FRAC_W), .OFS_W(OFS_W)
   ) i_calib (
      .code(a_code), .ch(a_col[CH_W-1:0]), .slope_bus(cal_slope),
      .offset_bus(cal_offset), .corrected(corr_w)
   );

   fdh_reduce #(.DATA_W(DATA_W), .RED_W(RED_W)) i_reduce (
      .cur(b_corr), .prev(b_prev), .shift(shift_amt), .reduced(red_w)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         a_valid   <= 1'b0;
         b_valid   <= 1'b0;
         c_valid   <= 1'b0;
         out_valid <= 1'b0;
         out_hit   <= 1'b0;
         out_diff  <= '0;
         out_row   <= '0;
         out_col   <= '0;
      end else begin
         a_valid   <= in_valid;
         b_valid   <= a_valid;
         c_valid   <= b_valid;
         out_valid <= c_valid;
         out_hit   <= c_valid && c_prev_ok && ($signed(c_red) > $signed(hit_thresh));
         out_diff  <= c_red;
         out_row   <= c_row;
         out_col   <= c_col;
      end
   end

   always_ff @(posedge clk) begin
      a_prev_ok <= p_prev_ok;
      a_row     <= p_row;
      a_col     <= p_col;
      a_addr    <= p_addr;
      a_code    <= in_data;
      b_prev_ok <= a_prev_ok;
      b_row     <= a_row;
      b_col     <= a_col;
      b_addr    <= a_addr;
      b_corr    <= corr_w;
      b_prev    <= a_prev;
      c_prev_ok <= b_prev_ok;
      c_row     <= b_row;
      c_col     <= b_col;
      c_red     <= b_prev_ok ? red_w : '0;
   end
endmodule

// File: rtl/fdh_hit_detector_chk.sv
module fdh_hit_detector_chk #(
   parameter int ROWS  = 16,
   parameter int COLS  = 32,
   parameter int RED_W = 8,
   localparam int ROW_W = $clog2(ROWS),
   localparam int COL_W = $clog2(COLS)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_valid,
   input logic [RED_W-1:0] hit_thresh,
   input logic             out_valid,
   input logic [RED_W-1:0] out_diff,
   input logic             out_hit,
   input logic [ROW_W-1:0] out_row,
   input logic [COL_W-1:0] out_col
);
   logic [2:0]       since_rst;
   logic             seen_q;
   logic [1:0]       frames_q;
   logic [ROW_W-1:0] last_row;
   logic [COL_W-1:0] last_col;
   logic             origin;

   assign origin = (out_row == '0) && (out_col == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         since_rst <= '0;
         seen_q    <= 1'b0;
         frames_q  <= '0;
         last_row  <= '0;
         last_col  <= '0;
      end else begin
         if (since_rst != 3'd7) since_rst <= since_rst + 3'd1;
         if (out_valid) begin
            seen_q   <= 1'b1;
            last_row <= out_row;
            last_col <= out_col;
            if (origin && frames_q != 2'd2) frames_q <= frames_q + 2'd1;
         end
      end
   end

   AST_OUT_TRACKS_IN: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst >= 3'd5) |-> (out_valid == $past(in_valid, 4))); // R2
   AST_HIT_HAS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      out_hit |-> out_valid); // R8
   AST_HIT_ABOVE_THRESH: assert property (@(posedge clk) disable iff (!rst_n)
      (out_hit && since_rst >= 3'd2) |-> ($signed(out_diff) > $signed($past(hit_thresh)))); // R8
   AST_POS_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_row < ROW_W'(ROWS - 1) || out_row == ROW_W'(ROWS - 1))
                 && (out_col < COL_W'(COLS - 1) || out_col == COL_W'(COLS - 1))); // R3
   AST_COL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && seen_q && out_col != '0) |->
         (out_col == last_col + 1'b1 && out_row == last_row)); // R3
   AST_ROW_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && seen_q && out_col == '0 && out_row != '0) |->
         (last_col == COL_W'(COLS - 1) && out_row == last_row + 1'b1)); // R3
   AST_FIRST_FRAME_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && (frames_q == 2'd0 || (frames_q == 2'd1 && !origin))) |->
         (!out_hit && out_diff == '0)); // R9
endmodule

bind fdh_hit_detector fdh_hit_detector_chk #(
   .ROWS(ROWS), .COLS(COLS), .RED_W(RED_W)
) i_fdh_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .hit_thresh(hit_thresh),
   .out_valid(out_valid), .out_diff(out_diff), .out_hit(out_hit),
   .out_row(out_row), .out_col(out_col)
);

// File: tb/test_fdh_hit_detector.sv
module test_fdh_hit_detector;
   localparam int CLK_PERIOD = 20;
   localparam int DATA_W = 12, ROWS = 3, COLS = 8, NUM_CH = 4;
   localparam int SLOPE_W = 12, FRAC_W = 8, OFS_W = 13, RED_W = 8;
   localparam int NPIX = ROWS * COLS;
   localparam int SHIFT_W = $clog2(DATA_W + 1);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic in_valid = 1'b0, in_sof = 1'b0;
   logic [DATA_W-1:0] in_data = '0;
   logic [NUM_CH*SLOPE_W-1:0] cal_slope = '0;
   logic [NUM_CH*OFS_W-1:0] cal_offset = '0;
   logic [SHIFT_W-1:0] shift_amt = '0;
   logic [RED_W-1:0] hit_thresh = '0;
   logic out_valid, out_hit;
   logic [RED_W-1:0] out_diff;
   logic [$clog2(ROWS)-1:0] out_row;
   logic [$clog2(COLS)-1:0] out_col;

   fdh_hit_detector #(
      .DATA_W(DATA_W), .ROWS(ROWS), .COLS(COLS), .NUM_CH(NUM_CH),
      .SLOPE_W(SLOPE_W), .FRAC_W(FRAC_W), .OFS_W(OFS_W), .RED_W(RED_W)
   ) i_fdh_hit_detector (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
      .in_data(in_data), .cal_slope(cal_slope), .cal_offset(cal_offset),
      .shift_amt(shift_amt), .hit_thresh(hit_thresh),
      .out_valid(out_valid), .out_diff(out_diff), .out_hit(out_hit),
      .out_row(out_row), .out_col(out_col)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int n_checks = 0, n_fail = 0;
   string cur_tag = "R1";

   // bench model state
   int store_m [NPIX];
   int mr = 0, mc = 0, maddr = 0;
   bit m_started = 0, m_prev = 0;
   int slope_m [NUM_CH];
   int ofs_m [NUM_CH];
   int shift_m = 0, thresh_m = 0;

   // expected output queue
   int    exp_diff [1024];
   bit    exp_hit  [1024];
   int    exp_row  [1024];
   int    exp_col  [1024];
   string exp_tag  [1024];
   int    q_head = 0, q_tail = 0;

   function automatic int clampi(int v, int lo, int hi);
      return (v < lo) ? lo : (v > hi) ? hi : v;
   endfunction

   task automatic check(bit ok, string tag, string what, int got, int expv);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: %s got %0d expected %0d", tag, what, got, expv);
      end
   endtask

   task automatic set_cfg(int s0, int s1, int s2, int s3, int o0, int o1, int o2, int o3,
                          int sh, int th);
      slope_m[0] = s0; slope_m[1] = s1; slope_m[2] = s2; slope_m[3] = s3;
      ofs_m[0] = o0; ofs_m[1] = o1; ofs_m[2] = o2; ofs_m[3] = o3;
      for (int k = 0; k < NUM_CH; k++) begin
         cal_slope[k*SLOPE_W +: SLOPE_W] = SLOPE_W'(slope_m[k]);
         cal_offset[k*OFS_W +: OFS_W]   = OFS_W'(ofs_m[k]);
      end
      shift_m = sh; thresh_m = th;
      shift_amt  = SHIFT_W'(sh);
      hit_thresh = RED_W'(th);
   endtask

   task automatic send(bit sof, int code);
      int ch, term, corr, diff, red;
      bit pok, hit;
      @(negedge clk);
      in_valid = 1'b1; in_sof = sof; in_data = DATA_W'(code);
      if (sof) begin mr = 0; mc = 0; maddr = 0; end
      pok  = m_prev || (m_started && mr == 0 && mc == 0);
      ch   = mc % NUM_CH;
      term = (slope_m[ch] * code) >>> FRAC_W;
      corr = clampi(code + term + ofs_m[ch], 0, 4095);
      diff = corr - store_m[maddr];
      red  = clampi(diff >>> shift_m, -128, 127);
      if (!pok) red = 0;
      hit  = pok && (red > thresh_m);
      exp_diff[q_tail] = red; exp_hit[q_tail] = hit;
      exp_row[q_tail] = mr; exp_col[q_tail] = mc; exp_tag[q_tail] = cur_tag;
      q_tail++;
      store_m[maddr] = corr;
      m_started = 1; m_prev = pok;
      if (mc == COLS-1) begin
         mc = 0; mr = (mr == ROWS-1) ? 0 : mr + 1;
      end else mc++;
      maddr = (maddr == NPIX-1) ? 0 : maddr + 1;
   endtask

   task automatic idle(int n, bit junk_sof);
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         in_valid = 1'b0; in_sof = junk_sof; in_data = DATA_W'(k * 1111);
      end
      in_sof = 1'b0;
   endtask

   task automatic drain(string tag);
      idle(8, 0);
      check(q_head == q_tail, tag, "outputs outstanding", q_tail - q_head, 0);
   endtask

   // output monitor
   always @(negedge clk) begin
      if (rst_n && out_valid) begin
         if (q_head == q_tail) begin
            check(0, "R2", "unexpected output count", 1, 0);
         end else begin
            n_checks++;
            if ($signed(out_diff) != exp_diff[q_head] || out_hit != exp_hit[q_head] ||
                int'(out_row) != exp_row[q_head] || int'(out_col) != exp_col[q_head]) begin
               n_fail++;
               $display("FAIL %s: got diff=%0d hit=%0b row=%0d col=%0d expected diff=%0d hit=%0b row=%0d col=%0d",
                  exp_tag[q_head], $signed(out_diff), out_hit, out_row, out_col,
                  exp_diff[q_head], exp_hit[q_head], exp_row[q_head], exp_col[q_head]);
            end
            q_head++;
         end
      end
   end

   task automatic t_reset;
      cur_tag = "R1";
      repeat (3) @(negedge clk);
      check(out_valid == 1'b0 && out_hit == 1'b0, "R1", "outputs during reset", out_valid, 0);
      rst_n = 1'b1;
      repeat (6) @(negedge clk);
      check(out_valid == 1'b0 && out_hit == 1'b0, "R1", "outputs idle after reset", out_valid, 0);
   endtask

   task automatic t_first_frame;
      cur_tag = "R9";
      set_cfg(0, 0, 0, 0, 0, 0, 0, 0, 0, 5);
      for (int i = 0; i < NPIX; i++) send(i == 0, 1000 + i * 3);
      drain("R9");
   endtask

   task automatic t_diff_hits;
      int delta [5] = '{-4, 0, 5, 6, 12};
      cur_tag = "R6/R8";
      for (int i = 0; i < NPIX; i++) send(i == 0, 1000 + i * 3 + delta[i % 5]);
      drain("R6/R8");
   endtask

   task automatic t_calib;
      cur_tag = "R4/R5";
      set_cfg(-3, 64, -128, 32, 0, 10, -20, 300, 0, 15);
      for (int i = 0; i < NPIX; i++)
         send(i == 0, (i == 3) ? 4000 : (i == 2) ? 30 : 2000 + i * 5);
      for (int i = 0; i < NPIX; i++)
         send(i == 0, (i == 3) ? 4095 : (i == 2) ? 10 : (i == 10) ? 100 : 2000 + i * 5 + 40);
      drain("R4/R5");
   endtask

   task automatic t_reduce;
      int delta [8] = '{1000, -1000, 20, -20, 13, 0, -9, 600};
      cur_tag = "R7";
      set_cfg(0, 0, 0, 0, 0, 0, 0, 0, 2, 3);
      for (int i = 0; i < NPIX; i++) send(i == 0, 2000);
      for (int i = 0; i < NPIX; i++) send(i == 0, 2000 + delta[i % 8]);
      drain("R7");
   endtask

   task automatic t_gaps;
      cur_tag = "R3";
      set_cfg(0, 0, 0, 0, 0, 0, 0, 0, 0, 20);
      for (int i = 0; i < NPIX + 5; i++) begin
         send(i == 0, 2000 + i * 3);
         idle(i % 3, 1);
      end
      drain("R3");
   endtask

   task automatic t_sof_restart;
      cur_tag = "R10";
      for (int i = 0; i < 5; i++) send(i == 0, 1500 + i * 2);
      for (int i = 0; i < NPIX; i++) send(i == 0, 1530 + i);
      drain("R10");
   endtask

   task automatic t_latency;
      cur_tag = "R2";
      send(0, 777);
      for (int k = 1; k <= 5; k++) begin
         @(negedge clk);
         in_valid = 1'b0;
         if (k < 4) check(out_valid == 1'b0, "R2", "early out_valid", out_valid, 0);
         else if (k == 4) check(out_valid == 1'b1, "R2", "out_valid at edge 4", out_valid, 1);
         else check(out_valid == 1'b0, "R2", "out_valid width", out_valid, 0);
      end
      drain("R2");
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_checks++; n_fail++;
      $display("FAIL watchdog: run did not finish, got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end

   initial begin
      t_reset();
      t_first_frame();
      t_diff_hits();
      t_calib();
      t_reduce();
      t_gaps();
      t_sof_restart();
      t_latency();
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end
endmodule